// File: doc/BRIEF.md
# PCM Serial Port with Frame-Sync Detection

This block is the digital serial side of a telephony voice channel. It moves 8-bit companded samples between the channel's encoder and decoder and a PCM highway. The transmit and receive directions each have a bit clock and a frame sync. All of these pins are sampled on a single fast system clock `clk_i`, and their edges are found by comparing each sample with the one before it. The encoder hands over a finished word with a load strobe. At the next transmit sync the port shifts that word out sign bit first, on a data output with a separate enable that models a tri-state pin. While the bits are on the wire, an open-drain style slot indicator is pulled low.

The port measures how long the transmit sync stays high and sorts it into one of two framing modes. The mode chosen at the end of one sync pulse sets how the output enable is timed and how the receive word is framed from the next frame on. In short mode the sync is one bit clock wide: the sync is sampled on a falling bit-clock edge, and the output opens on the rising edge that follows. In long mode the sync is three or more bit clocks wide: the output opens when sync and bit clock are both high, and it closes when the bits are finished and sync has fallen, whichever of the two comes last. On the receive side the port collects eight bits sign first and presents the byte with a one-cycle strobe. In synchronous mode the receive side can take its bit clock from the transmit side.

Top module: `pcm_serial_port`

## Requirements
- R1: Out of reset the output enable is 0, the slot indicator `tx_slot_no` is 1 (released), `long_mode_o` is 0 (short mode), `fs_err_o` is 0 and `rx_valid_o` is 0.
- R2: When the transmit sync falls, the port counts the falling bit-clock edges that saw sync high. A count of 1 selects short mode (`long_mode_o`=0) and a count of 3 or more selects long mode (`long_mode_o`=1). The mode changes at no other time.
- R3: A count of exactly 2 selects short mode and sets `fs_err_o`=1. The flag holds its value until the next sync fall, which sets it again from the new count.
- R4: Short mode, transmit. A falling bit-clock edge with sync high arms the port. The next rising edge enables the output and drives bit 7 (the sign). Each of the next seven rising edges drives the next lower bit. The falling edge after the eighth rising edge disables the output. The data output changes only on a rising bit-clock edge.
- R5: Long mode, transmit. The output is enabled with bit 7 at the first system-clock cycle in which sync and bit clock are both high. This happens on the sync rise if the bit clock is already high, and otherwise on the next bit-clock rise.
- R6: Long mode, transmit. The output is disabled at the later of two events: the falling bit-clock edge after the eighth rising edge, and the transmit sync going low.
- R7: A slot sends the word that was last loaded with `tx_load_i` before the slot began. A load during a slot does not change the bits of that slot and is sent in the next slot.
- R8: `tx_slot_no` is 0 from the output enable until the falling edge after the eighth rising edge, and 1 at all other times. It is never 0 while the output is disabled.
- R9: Short mode, receive. The falling receive bit-clock edge that sees receive sync high is a marker and latches no data. The next eight falling edges latch `rx_data_i`, MSB first. One cycle after the eighth of them, `rx_valid_o` is 1 for exactly one cycle, and `rx_word_o` holds the byte.
- R10: Long mode, receive. A rising edge of the receive sync makes the next eight falling bit-clock edges latch the word, MSB first. Completion is reported as in R9.
- R11: A new receive sync start in the middle of a word drops the partial word without a strobe and starts a fresh word.
- R12: With `sync_mode_i`=1 the receive side is clocked by `tx_bclk_i`, and edges on `rx_bclk_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_mode_i | input | 1 | 1: receive side uses the transmit bit clock |
| tx_bclk_i | input | 1 | Transmit bit clock |
| tx_fs_i | input | 1 | Transmit frame sync |
| tx_load_i | input | 1 | Strobe from the encoder: capture `tx_word_i` |
| tx_word_i | input | 8 | Encoded sample to send in the next slot |
| tx_data_o | output | 1 | Serial transmit data, valid while `tx_oe_o` is 1 |
| tx_oe_o | output | 1 | Output enable of the tri-state data pin |
| tx_slot_no | output | 1 | Slot indicator, 0 while the 8-bit slot is active |
| long_mode_o | output | 1 | Detected framing mode, 1 for long sync |
| fs_err_o | output | 1 | Last transmit sync was two bit clocks wide |
| rx_bclk_i | input | 1 | Receive bit clock |
| rx_fs_i | input | 1 | Receive frame sync |
| rx_data_i | input | 1 | Serial receive data |
| rx_word_o | output | 8 | Last complete received word |
| rx_valid_o | output | 1 | One-cycle strobe when `rx_word_o` is updated |

## Verification
Two cases put events in the same cycle. In the first, a long-mode slot reaches its eighth falling edge while the transmit sync is still high. The end of the slot and the hold of the output enable then land together. The bench keeps the sync high past that edge and checks two things at that sample: the slot indicator has been released and the enable is still set. It then checks that the enable drops in the cycle after the sync falls. In the second case, an encoder load arrives in the middle of a slot, at the same time as bits are shifting out. The bench checks that the current slot still carries the old word and the next slot carries the new one.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  localparam int PCM_WORD_W = 8;
  localparam int FS_LONG_MIN = 3;
  // edge detector lanes
  localparam int EDG_TX_BCLK = 0;
  localparam int EDG_TX_FS   = 1;
  localparam int EDG_RX_BCLK = 2;
  localparam int EDG_RX_FS   = 3;
  localparam int EDG_N       = 4;
endpackage

// File: rtl/pcm_edge_det.sv
module pcm_edge_det #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= '0;
    else         sig_q <= sig_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_lane
    assign rise_o[g] =  sig_i[g] & ~sig_q[g];
    assign fall_o[g] = ~sig_i[g] &  sig_q[g];
  end
endmodule

// File: rtl/pcm_fs_detect.sv
module pcm_fs_detect #(
  parameter int LONG_MIN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fs_i,
  input  logic fs_rise_i,
  input  logic fs_fall_i,
  input  logic bclk_fall_i,
  output logic long_mode_o,
  output logic fs_err_o
);
  localparam int CW = $clog2(LONG_MIN + 1);
  localparam logic [CW-1:0] SAT = CW'(LONG_MIN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      long_mode_o <= 1'b0;
      fs_err_o    <= 1'b0;
    end else begin
      if (fs_rise_i) begin
        cnt_q <= '0;
      end else if (bclk_fall_i && fs_i && cnt_q != SAT) begin
        cnt_q <= cnt_q + 1'b1;
      end
      // decide on sync fall; a pulse with no falling edge leaves mode alone
      if (fs_fall_i && cnt_q != '0) begin
        long_mode_o <= (cnt_q == SAT);
        fs_err_o    <= (cnt_q == CW'(2));
      end
    end
  end

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fs_fall_i |=> $stable(long_mode_o)); // R2
  AST_ERR_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_err_o |-> !long_mode_o); // R3
endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              long_mode_i,
  input  logic              fs_i,
  input  logic              bclk_i,
  input  logic              bclk_rise_i,
  input  logic              bclk_fall_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              data_o,
  output logic              oe_o,
  output logic              slot_no
);
  localparam int BW = $clog2(WORD_W + 1);
  localparam logic [BW-1:0] LAST = BW'(WORD_W);

  logic [WORD_W-1:0] buf_q, sr_q;
  logic [BW-1:0]     bit_q;
  logic              active_q, armed_q, fs_seen_q;
  logic              start_short, start_long;

  assign start_short = armed_q && bclk_rise_i && !long_mode_i && !active_q;
  assign start_long  = long_mode_i && fs_i && bclk_i && !fs_seen_q && !active_q;
  assign slot_no     = ~active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) buf_q <= '0;
    else if (load_i) buf_q <= word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q      <= '0;
      bit_q     <= '0;
      active_q  <= 1'b0;
      armed_q   <= 1'b0;
      fs_seen_q <= 1'b0;
      oe_o      <= 1'b0;
      data_o    <= 1'b0;
    end else begin
      if (!fs_i) fs_seen_q <= 1'b0;
      if (long_mode_i) armed_q <= 1'b0;
      else if (bclk_fall_i && fs_i && !active_q) armed_q <= 1'b1;

      if (start_short || start_long) begin
        data_o    <= buf_q[WORD_W-1];
        sr_q      <= buf_q << 1;
        bit_q     <= BW'(1);
        active_q  <= 1'b1;
        oe_o      <= 1'b1;
        armed_q   <= 1'b0;
        fs_seen_q <= start_long;
      end else if (active_q) begin
        if (bclk_rise_i && bit_q != LAST) begin
          data_o <= sr_q[WORD_W-1];
          sr_q   <= sr_q << 1;
          bit_q  <= bit_q + 1'b1;
        end else if (bclk_fall_i && bit_q == LAST) begin
          active_q <= 1'b0;
          // long mode: enable held until sync drops
          oe_o     <= long_mode_i && fs_i;
        end
      end else if (oe_o && !fs_i) begin
        oe_o <= 1'b0;
      end
    end
  end

  AST_SLOT_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_no |-> oe_o); // R8
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !bclk_rise_i) |=> $stable(data_o)); // R4
endmodule

// File: rtl/pcm_rx_shifter.sv
module pcm_rx_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              long_mode_i,
  input  logic              fs_i,
  input  logic              fs_rise_i,
  input  logic              bclk_fall_i,
  input  logic              data_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [WORD_W-1:0] sr_q;
  logic [CW-1:0]     cnt_q;
  logic              act_q, start;

  assign start = long_mode_i ? fs_rise_i : (bclk_fall_i && fs_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      act_q   <= 1'b0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start) begin
        act_q <= 1'b1;
        cnt_q <= '0;
      end else if (act_q && bclk_fall_i) begin
        sr_q <= {sr_q[WORD_W-2:0], data_i};
        if (cnt_q == LAST) begin
          word_o  <= {sr_q[WORD_W-2:0], data_i};
          valid_o <= 1'b1;
          act_q   <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R9
  AST_WORD_ON_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(word_o)); // R10
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_port_pkg::*;
#(
  parameter int WORD_W   = PCM_WORD_W,
  parameter int LONG_MIN = FS_LONG_MIN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_mode_i,
  input  logic              tx_bclk_i,
  input  logic              tx_fs_i,
  input  logic              tx_load_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              tx_data_o,
  output logic              tx_oe_o,
  output logic              tx_slot_no,
  output logic              long_mode_o,
  output logic              fs_err_o,
  input  logic              rx_bclk_i,
  input  logic              rx_fs_i,
  input  logic              rx_data_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o
);
  logic [EDG_N-1:0] lvl, rise, fall;
  logic             rx_bclk_sel;
  logic             unused_edges;

  assign rx_bclk_sel = sync_mode_i ? tx_bclk_i : rx_bclk_i;
  assign lvl[EDG_TX_BCLK] = tx_bclk_i;
  assign lvl[EDG_TX_FS]   = tx_fs_i;
  assign lvl[EDG_RX_BCLK] = rx_bclk_sel;
  assign lvl[EDG_RX_FS]   = rx_fs_i;
  assign unused_edges = ^{rise[EDG_RX_BCLK], fall[EDG_RX_FS]};

  pcm_edge_det #(.N(EDG_N)) u_edge (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .sig_i (lvl), .rise_o (rise), .fall_o (fall)
  );

  pcm_fs_detect #(.LONG_MIN(LONG_MIN)) u_fsdet (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fs_i        (tx_fs_i),
    .fs_rise_i   (rise[EDG_TX_FS]),
    .fs_fall_i   (fall[EDG_TX_FS]),
    .bclk_fall_i (fall[EDG_TX_BCLK]),
    .long_mode_o (long_mode_o),
    .fs_err_o    (fs_err_o)
  );

  pcm_tx_shifter #(.WORD_W(WORD_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .long_mode_i (long_mode_o),
    .fs_i        (tx_fs_i),
    .bclk_i      (tx_bclk_i),
    .bclk_rise_i (rise[EDG_TX_BCLK]),
    .bclk_fall_i (fall[EDG_TX_BCLK]),
    .load_i      (tx_load_i),
    .word_i      (tx_word_i),
    .data_o      (tx_data_o),
    .oe_o        (tx_oe_o),
    .slot_no     (tx_slot_no)
  );

  pcm_rx_shifter #(.WORD_W(WORD_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .long_mode_i (long_mode_o),
    .fs_i        (rx_fs_i),
    .fs_rise_i   (rise[EDG_RX_FS]),
    .bclk_fall_i (fall[EDG_RX_BCLK]),
    .data_i      (rx_data_i),
    .word_o      (rx_word_o),
    .valid_o     (rx_valid_o)
  );

  AST_RX_QUIET_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !rx_valid_o); // R1
endmodule

// File: tb/sim_pcm_serial_port.sv
module sim_pcm_serial_port;
  logic clk = 0, rst_ni = 0;
  logic sync_mode = 0, tx_bclk = 0, tx_fs = 0, tx_load = 0;
  logic [7:0] tx_word = 0;
  logic rx_bclk = 0, rx_fs = 0, rx_data = 0;
  logic tx_data_o, tx_oe_o, tx_slot_no, long_mode_o, fs_err_o, rx_valid_o;
  logic [7:0] rx_word_o;
  int checks = 0, errors = 0, vcnt = 0;

  always #10 clk = ~clk;

  pcm_serial_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sync_mode_i(sync_mode),
    .tx_bclk_i(tx_bclk), .tx_fs_i(tx_fs), .tx_load_i(tx_load), .tx_word_i(tx_word),
    .tx_data_o(tx_data_o), .tx_oe_o(tx_oe_o), .tx_slot_no(tx_slot_no),
    .long_mode_o(long_mode_o), .fs_err_o(fs_err_o),
    .rx_bclk_i(rx_bclk), .rx_fs_i(rx_fs), .rx_data_i(rx_data),
    .rx_word_o(rx_word_o), .rx_valid_o(rx_valid_o)
  );

  always @(negedge clk) if (rst_ni && rx_valid_o) vcnt++;

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic rbc(input logic lvl, input bit use_tx);
    if (use_tx) tx_bclk = lvl; else rx_bclk = lvl;
  endtask

  task automatic load(input logic [7:0] w);
    tx_word = w; tx_load = 1; step(1); tx_load = 0;
  endtask

  task automatic t_reset;
    step(3);
    chk("R1", "oe", tx_oe_o, 0); chk("R1", "slot", tx_slot_no, 1);
    chk("R1", "long", long_mode_o, 0); chk("R1", "err", fs_err_o, 0);
    chk("R1", "valid", rx_valid_o, 0);
    rst_ni = 1; step(2);
    chk("R1", "oe after", tx_oe_o, 0); chk("R1", "long after", long_mode_o, 0);
  endtask

  task automatic rx_frame(input logic [7:0] w, input bit use_tx, input bit is_long, input string req);
    int v0;
    v0 = vcnt;
    rbc(1, use_tx); step(2);
    rx_fs = 1; step(2);
    if (!is_long) begin
      rbc(0, use_tx); step(2); rbc(1, use_tx); step(1); rx_fs = 0; step(1);
    end
    for (int i = 7; i >= 0; i--) begin
      rx_data = w[i]; rbc(0, use_tx); step(1);
      if (i == 0) begin
        chk(req, "valid", rx_valid_o, 1); chk(req, "word", rx_word_o, w);
      end
      step(1);
      if (i == 0) chk(req, "valid pulse end", rx_valid_o, 0);
      if (is_long && i == 4) rx_fs = 0;
      rbc(1, use_tx); step(2);
    end
    rbc(0, use_tx); step(2);
    chk(req, "strobe count", vcnt - v0, 1);
  endtask

  task automatic t_rx_restart;
    int v0;
    v0 = vcnt;
    rx_bclk = 1; step(2); rx_fs = 1; step(2);
    rx_bclk = 0; step(2); rx_bclk = 1; step(1); rx_fs = 0; step(1);
    for (int i = 0; i < 3; i++) begin
      rx_data = i[0]; rx_bclk = 0; step(2); rx_bclk = 1; step(2);
    end
    rx_bclk = 0; step(2);
    rx_frame(8'h5E, 0, 0, "R11");
    chk("R11", "no strobe for partial", vcnt - v0, 1);
  endtask

  task automatic t_rx_sync;
    int v0;
    sync_mode = 1; step(2);
    v0 = vcnt;
    rx_bclk = 1; step(2); rx_fs = 1; step(2); rx_bclk = 0; step(2); rx_fs = 0;
    for (int i = 0; i < 9; i++) begin
      rx_data = 1; rx_bclk = 1; step(2); rx_bclk = 0; step(2);
    end
    step(2);
    chk("R12", "rx_bclk ignored", vcnt - v0, 0);
    rx_frame(8'h69, 1, 0, "R12");
    sync_mode = 0; step(2);
  endtask

  task automatic t_width2;
    tx_bclk = 1; step(2); tx_fs = 1; step(2);
    for (int i = 0; i < 2; i++) begin
      tx_bclk = 0; step(2); tx_bclk = 1; step(2);
    end
    tx_fs = 0; step(2);
    chk("R3", "err", fs_err_o, 1); chk("R3", "short", long_mode_o, 0);
    for (int i = 0; i < 8; i++) begin
      tx_bclk = 0; step(2); tx_bclk = 1; step(2);
    end
    tx_bclk = 0; step(2);
    chk("R3", "slot idle", tx_oe_o, 0);
  endtask

  task automatic tx_short(input logic [7:0] w, input bit load_mid, input logic [7:0] w_new);
    tx_bclk = 1; step(2); tx_fs = 1; step(2); tx_bclk = 0; step(2);
    chk("R4", "oe before rise", tx_oe_o, 0);
    tx_bclk = 1; step(1);
    chk("R4", "oe on", tx_oe_o, 1); chk("R4", "sign", tx_data_o, w[7]);
    chk("R8", "slot low", tx_slot_no, 0);
    step(1); tx_fs = 0; step(2);
    for (int i = 6; i >= 0; i--) begin
      tx_bclk = 0; step(1);
      chk("R4", "oe mid", tx_oe_o, 1);
      if (load_mid && i == 4) begin tx_word = w_new; tx_load = 1; step(1); tx_load = 0; end
      else step(1);
      tx_bclk = 1; step(1);
      chk(load_mid ? "R7" : "R4", "bit", tx_data_o, w[i]);
      step(1);
    end
    tx_bclk = 0; step(1);
    chk("R4", "oe off", tx_oe_o, 0); chk("R8", "slot released", tx_slot_no, 1);
    step(1);
  endtask

  task automatic t_long_train;
    tx_bclk = 1; step(2); tx_fs = 1; step(2);
    for (int i = 0; i < 4; i++) begin
      tx_bclk = 0; step(2); tx_bclk = 1; step(2);
    end
    tx_fs = 0; step(1);
    chk("R2", "long set", long_mode_o, 1); chk("R2", "err clear", fs_err_o, 0);
    step(1);
    for (int i = 0; i < 8; i++) begin
      tx_bclk = 0; step(2); tx_bclk = 1; step(2);
    end
    tx_bclk = 0; step(2);
    chk("R6", "idle after train", tx_oe_o, 0);
  endtask

  task automatic tx_long(input logic [7:0] w, input bit fs_first, input bit fs_hold);
    if (fs_first) begin
      tx_bclk = 0; step(2); tx_fs = 1; step(1);
      chk("R5", "wait bclk", tx_oe_o, 0);
      step(1); tx_bclk = 1; step(1);
    end else begin
      tx_bclk = 1; step(2);
      chk("R5", "wait fs", tx_oe_o, 0);
      tx_fs = 1; step(1);
    end
    chk("R5", "oe on", tx_oe_o, 1); chk("R5", "sign", tx_data_o, w[7]);
    step(1);
    for (int i = 6; i >= 0; i--) begin
      tx_bclk = 0; step(2); tx_bclk = 1; step(1);
      chk("R5", "bit", tx_data_o, w[i]);
      step(1);
      if (!fs_hold && i == 4) begin tx_fs = 0; step(2); end
    end
    tx_bclk = 0; step(1);
    if (fs_hold) begin
      chk("R6", "oe held by sync", tx_oe_o, 1); chk("R8", "slot ended", tx_slot_no, 1);
      step(1); tx_fs = 0; step(1);
      chk("R6", "oe off at sync low", tx_oe_o, 0);
    end else begin
      chk("R6", "oe off at fall", tx_oe_o, 0);
    end
    step(1);
    chk("R2", "long kept", long_mode_o, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    rx_frame(8'hC3, 0, 0, "R9");
    t_rx_restart();
    t_rx_sync();
    load(8'hA5);
    t_width2();
    tx_short(8'hA5, 1, 8'h3C);
    chk("R3", "err cleared", fs_err_o, 0);
    tx_short(8'h3C, 0, 8'h00);
    t_long_train();
    tx_long(8'h3C, 1, 0);
    load(8'h5A);
    tx_long(8'h5A, 0, 1);
    rx_frame(8'h96, 0, 1, "R10");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule